// File: doc/BRIEF.md
# Frame Buffer Display Reader

This block drives a monitor from frames held in external memory. It runs horizontal and vertical counters against timing values that software writes. From these counters it makes the sync pulses and the data-enable window for any progressive format whose line and frame totals fit in 12 bits, which includes a 2200 x 1125 total. Software writes the timing values, the sync polarity, three frame-buffer start addresses and a memory command word through a one-cycle register-write port in the pixel clock domain.

A writer in another clock domain announces, as a Gray-coded index, which of the three buffers it is filling. At the start of every vertical sync pulse the reader takes the synchronized index and picks the buffer one step behind it, wrapping modulo three. It then places a single-cycle read request for that buffer on the memory controller's command FIFO. During active video it takes one pixel per cycle from a first-word-fall-through read FIFO. When that FIFO runs dry, it sends black and latches an underflow flag.

Top module: `vid_scan_fetch`

## Requirements
- R1: A line lasts h_active+h_front+h_sync+h_back cycles, a frame lasts v_active+v_front+v_sync+v_back lines, and `de` is high exactly for the first h_active cycles of each of the first v_active lines. Each value is 12 bits, and the line length is at least 2.
- R2: `hsync` is in its active state for h_sync cycles, starting h_active+h_front cycles into each line. Polarity bit 0 set to 1 means hsync is active-low; cleared means active-high.
- R3: `vsync` is in its active state for whole lines v_active+v_front through v_active+v_front+v_sync-1. Polarity bit 1 selects its level in the same way as bit 0 does for hsync.
- R4: A write with `cfg_we` high is taken at the clock edge. Addresses: 0 h_active, 1 h_front, 2 h_sync, 3 h_back, 4 v_active, 5 v_front, 6 v_sync, 7 v_back (each from data bits 11:0), 8 polarity (bits 1:0), 9/10/11 start address of buffer 0/1/2, 12 command word. Outputs show the new value from the cycle after that edge. A write on the edge where a request is formed does not change that request.
- R5: `wr_idx_gray` passes through two flops before it is decoded (Gray 00, 01, 11, 10 mean 0, 1, 2, 3). At the first cycle of the first vsync line, the buffer chosen is (index+2) mod 3, and `cmd_addr` carries that buffer's start address.
- R6: `cmd_valid` is high for exactly one cycle per frame, one cycle after the first cycle of the first vsync line. `cmd_word` carries the command register value. Both command outputs hold their values between requests.
- R7: `rd_pop` is high in a cycle exactly when the counters are in active video and `rd_empty` is low. `pix_out` shows the popped `rd_data` one cycle later, aligned with `de`, `hsync` and `vsync`.
- R8: An active-video cycle with `rd_empty` high produces a `pix_out` of 0 in the next cycle and sets `underflow`, which stays set until reset.
- R9: A counter at or beyond its new total minus one after a timing write wraps to 0 on the next edge, so shrinking a total recovers within one line or frame.
- R10: During reset, `de`, `cmd_valid` and `underflow` are 0, `pix_out` and the command outputs are 0, and each sync output sits at its inactive level for the default polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_px | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 32 | Register write data |
| wr_idx_gray | input | 2 | Writer's Gray-coded buffer index, asynchronous |
| rd_empty | input | 1 | Read-data FIFO empty |
| rd_data | input | PIX_W | Read-data FIFO head word |
| rd_pop | output | 1 | Read-data FIFO pop |
| cmd_valid | output | 1 | Command FIFO write strobe |
| cmd_addr | output | ADDR_W | Start address of the chosen buffer |
| cmd_word | output | 32 | Command word for the read |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| pix_out | output | PIX_W | Pixel to the transmitter |
| underflow | output | 1 | Sticky read-FIFO underflow |

## Verification
Two things can land on the same clock edge: forming the read request at the start of vsync, and a software write to the start address of the buffer being chosen. The bench waits until its own counter model stands one cycle before the start of the first vsync line. It then raises the write strobe for that buffer's address, so the write and the request share one edge. The request must carry the old address and the next frame's request the new one. The bench also changes the Gray index and the FIFO empty pattern at points that fall near the request edge and inside active video, and it compares every output against its cycle model on every cycle.

// File: rtl/vsf_pkg.sv
package vsf_pkg;
  localparam int CNT_W   = 12;
  localparam int NUM_BUF = 3;
  localparam int IDX_W   = 2;
  localparam int SEL_W   = $clog2(NUM_BUF);
  localparam int CFG_AW  = 4;

  localparam int ADR_H    = 0;
  localparam int ADR_V    = 4;
  localparam int ADR_POL  = 8;
  localparam int ADR_BASE = 9;
  localparam int ADR_CMD  = ADR_BASE + NUM_BUF;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    cnt_t act;
    cnt_t fp;
    cnt_t sw;
    cnt_t bp;
  } axis_t;

  function automatic cnt_t axis_total(axis_t a);
    return a.act + a.fp + a.sw + a.bp;
  endfunction

  function automatic logic in_pulse(cnt_t c, axis_t a);
    cnt_t lo;
    cnt_t hi;
    lo = a.act + a.fp;
    hi = lo + a.sw;
    return (c >= lo) && (c < hi);
  endfunction

  function automatic logic [IDX_W-1:0] gray_to_bin(logic [IDX_W-1:0] g);
    logic [IDX_W-1:0] b;
    b[IDX_W-1] = g[IDX_W-1];
    for (int i = IDX_W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic [SEL_W-1:0] prev_buf(logic [IDX_W-1:0] idx);
    int unsigned v;
    v = (int'(idx) + NUM_BUF - 1) % NUM_BUF;
    return SEL_W'(v);
  endfunction
endpackage

// File: rtl/vsf_regs.sv
module vsf_regs
  import vsf_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int H_ACT = 640, parameter int H_FP = 16, parameter int H_SW = 96, parameter int H_BP = 48,
  parameter int V_ACT = 480, parameter int V_FP = 10, parameter int V_SW = 2,  parameter int V_BP = 33,
  parameter logic [1:0]        POL_DEF   = 2'b11,
  parameter logic [ADDR_W-1:0] BASE_DEF  = '0,
  parameter logic [ADDR_W-1:0] BASE_STEP = ADDR_W'(32'h0004_B000),
  parameter logic [DATA_W-1:0] CMD_DEF   = '0
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [CFG_AW-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  output axis_t                             h_cfg,
  output axis_t                             v_cfg,
  output logic [1:0]                        pol,
  output logic [NUM_BUF-1:0][ADDR_W-1:0]    base,
  output logic [DATA_W-1:0]                 cmd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cfg <= '{act: cnt_t'(H_ACT), fp: cnt_t'(H_FP), sw: cnt_t'(H_SW), bp: cnt_t'(H_BP)};
      v_cfg <= '{act: cnt_t'(V_ACT), fp: cnt_t'(V_FP), sw: cnt_t'(V_SW), bp: cnt_t'(V_BP)};
      pol   <= POL_DEF;
      cmd   <= CMD_DEF;
    end else if (we) begin
      case (int'(addr))
        ADR_H + 0: h_cfg.act <= wdata[CNT_W-1:0];
        ADR_H + 1: h_cfg.fp  <= wdata[CNT_W-1:0];
        ADR_H + 2: h_cfg.sw  <= wdata[CNT_W-1:0];
        ADR_H + 3: h_cfg.bp  <= wdata[CNT_W-1:0];
        ADR_V + 0: v_cfg.act <= wdata[CNT_W-1:0];
        ADR_V + 1: v_cfg.fp  <= wdata[CNT_W-1:0];
        ADR_V + 2: v_cfg.sw  <= wdata[CNT_W-1:0];
        ADR_V + 3: v_cfg.bp  <= wdata[CNT_W-1:0];
        ADR_POL:   pol       <= wdata[1:0];
        ADR_CMD:   cmd       <= wdata;
        default: ;
      endcase
    end
  end

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_base
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        base[i] <= BASE_DEF + ADDR_W'(i) * BASE_STEP;
      else if (we && addr == CFG_AW'(ADR_BASE + i))
        base[i] <= wdata[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/vsf_timing.sv
module vsf_timing
  import vsf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  axis_t h_cfg,
  input  axis_t v_cfg,
  output logic  act_now,
  output logic  hs_on,
  output logic  vs_on,
  output logic  vs_begin
);
  cnt_t hcnt, vcnt;
  logic h_last, v_last;

  assign h_last   = hcnt >= axis_total(h_cfg) - cnt_t'(1);
  assign v_last   = vcnt >= axis_total(v_cfg) - cnt_t'(1);
  assign act_now  = (hcnt < h_cfg.act) && (vcnt < v_cfg.act);
  assign hs_on    = in_pulse(hcnt, h_cfg);
  assign vs_on    = in_pulse(vcnt, v_cfg);
  assign vs_begin = (hcnt == '0) && (vcnt == cnt_t'(v_cfg.act + v_cfg.fp));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (h_last) begin
      hcnt <= '0;
      vcnt <= v_last ? '0 : vcnt + cnt_t'(1);
    end else begin
      hcnt <= hcnt + cnt_t'(1);
    end
  end
endmodule

// File: rtl/vsf_gray_sync.sv
module vsf_gray_sync
  import vsf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] gray_in,
  output logic [IDX_W-1:0] bin_out
);
  logic [IDX_W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  assign bin_out = gray_to_bin(sync_q);
endmodule

// File: rtl/vid_scan_fetch.sv
module vid_scan_fetch
  import vsf_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int H_ACT = 640, parameter int H_FP = 16, parameter int H_SW = 96, parameter int H_BP = 48,
  parameter int V_ACT = 480, parameter int V_FP = 10, parameter int V_SW = 2,  parameter int V_BP = 33,
  parameter logic [1:0]        POL_DEF   = 2'b11,
  parameter logic [ADDR_W-1:0] BASE_DEF  = '0,
  parameter logic [ADDR_W-1:0] BASE_STEP = ADDR_W'(32'h0004_B000),
  parameter logic [DATA_W-1:0] CMD_DEF   = '0
) (
  input  logic              clk_px,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [IDX_W-1:0]  wr_idx_gray,
  input  logic              rd_empty,
  input  logic [PIX_W-1:0]  rd_data,
  output logic              rd_pop,
  output logic              cmd_valid,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_word,
  output logic              hsync,
  output logic              vsync,
  output logic              de,
  output logic [PIX_W-1:0]  pix_out,
  output logic              underflow
);
  axis_t                          h_cfg, v_cfg;
  logic [1:0]                     pol;
  logic [NUM_BUF-1:0][ADDR_W-1:0] base;
  logic [DATA_W-1:0]              cmd_q;
  logic                           act_now, hs_on, vs_on, vs_begin;
  logic [IDX_W-1:0]               wr_idx_bin;
  logic [SEL_W-1:0]               sel_next, sel_buf;
  logic                           starve;

  vsf_regs #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP),
    .POL_DEF(POL_DEF), .BASE_DEF(BASE_DEF), .BASE_STEP(BASE_STEP), .CMD_DEF(CMD_DEF)
  ) u_regs (
    .clk(clk_px), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .h_cfg(h_cfg), .v_cfg(v_cfg), .pol(pol), .base(base), .cmd(cmd_q)
  );

  vsf_timing u_tim (
    .clk(clk_px), .rst_n(rst_n), .h_cfg(h_cfg), .v_cfg(v_cfg),
    .act_now(act_now), .hs_on(hs_on), .vs_on(vs_on), .vs_begin(vs_begin)
  );

  vsf_gray_sync u_gsync (
    .clk(clk_px), .rst_n(rst_n), .gray_in(wr_idx_gray), .bin_out(wr_idx_bin)
  );

  assign sel_next = prev_buf(wr_idx_bin);
  assign rd_pop   = act_now && !rd_empty;
  assign starve   = act_now && rd_empty;

  always_ff @(posedge clk_px or negedge rst_n) begin
    if (!rst_n) begin
      cmd_valid <= 1'b0;
      cmd_addr  <= '0;
      cmd_word  <= '0;
      sel_buf   <= '0;
    end else if (vs_begin) begin
      cmd_valid <= 1'b1;
      cmd_addr  <= base[sel_next];
      cmd_word  <= cmd_q;
      sel_buf   <= sel_next;
    end else begin
      cmd_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk_px or negedge rst_n) begin
    if (!rst_n) begin
      de        <= 1'b0;
      hsync     <= POL_DEF[0];
      vsync     <= POL_DEF[1];
      pix_out   <= '0;
      underflow <= 1'b0;
    end else begin
      de        <= act_now;
      hsync     <= hs_on ^ pol[0];
      vsync     <= vs_on ^ pol[1];
      pix_out   <= rd_pop ? rd_data : '0;
      underflow <= underflow | starve;
    end
  end
endmodule

// File: rtl/vsf_chk.sv
module vsf_chk #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             act_now,
  input logic             rd_empty,
  input logic             rd_pop,
  input logic             vs_begin,
  input logic             cmd_valid,
  input logic             underflow,
  input logic [PIX_W-1:0] pix_out
);
  AST_POP_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n) rd_pop |-> (act_now && !rd_empty)); // R7
  AST_CMD_AFTER_VS: assert property (@(posedge clk) disable iff (!rst_n) vs_begin |=> cmd_valid); // R5
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) cmd_valid |=> !cmd_valid); // R6
  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n) underflow |=> underflow); // R8
  AST_BLACK_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (act_now && rd_empty) |=> (pix_out == '0)); // R8
  AST_UNDERFLOW_ON_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) (act_now && rd_empty) |=> underflow); // R8
endmodule

bind vid_scan_fetch vsf_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk_px), .rst_n(rst_n), .act_now(act_now), .rd_empty(rd_empty), .rd_pop(rd_pop),
  .vs_begin(vs_begin), .cmd_valid(cmd_valid), .underflow(underflow), .pix_out(pix_out)
);

// File: tb/sim_vid_scan_fetch.sv
`timescale 1ns/1ps
module sim_vid_scan_fetch;
  localparam int HA0 = 4, HF0 = 2, HS0 = 3, HB0 = 2;
  localparam int VA0 = 3, VF0 = 1, VS0 = 2, VB0 = 2;
  localparam logic [1:0]  POL0 = 2'b01;
  localparam logic [31:0] BASE0 = 32'h100, BSTEP = 32'h100, CMD0 = 32'hA5A5_0001;

  logic clk = 0, rst_n = 0, cfg_we = 0;
  logic [3:0] cfg_addr = 0;
  logic [31:0] cfg_wdata = 0;
  logic [1:0] wr_idx_gray = 0;
  logic rd_empty = 0;
  logic [7:0] rd_data = 0;
  logic rd_pop, cmd_valid, hsync, vsync, de, underflow;
  logic [31:0] cmd_addr, cmd_word;
  logic [7:0] pix_out;

  always #5 clk = ~clk;

  vid_scan_fetch #(
    .PIX_W(8), .DATA_W(32), .ADDR_W(32),
    .H_ACT(HA0), .H_FP(HF0), .H_SW(HS0), .H_BP(HB0),
    .V_ACT(VA0), .V_FP(VF0), .V_SW(VS0), .V_BP(VB0),
    .POL_DEF(POL0), .BASE_DEF(BASE0), .BASE_STEP(BSTEP), .CMD_DEF(CMD0)
  ) u0 (
    .clk_px(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .wr_idx_gray(wr_idx_gray), .rd_empty(rd_empty), .rd_data(rd_data), .rd_pop(rd_pop),
    .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_word(cmd_word), .hsync(hsync),
    .vsync(vsync), .de(de), .pix_out(pix_out), .underflow(underflow)
  );

  int nvec = 0, nmis = 0;
  bit done = 0, run_chk = 0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    nvec++;
    if (act != exp) begin
      nmis++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pix_of(int n);
    return 8'((n * 37 + 11) & 255);
  endfunction

  // bench-side timing model
  int mh, mv, ha, hf, hs, hb, va, vf, vs, vb;
  logic [1:0] pol, g1, g2;
  logic [31:0] base [3];
  logic [31:0] cmd;
  logic exp_de, exp_hs, exp_vs, exp_uf, exp_cv, exp_blk, pend_pop;
  logic [7:0] exp_pix;
  logic [31:0] exp_ca, exp_cw;
  int pcnt = 0, cyc = 0, empty_mode = 0;
  bit m_act;
  int m_b;

  always @(posedge clk) begin
    if (!rst_n) begin
      mh = 0; mv = 0;
      ha = HA0; hf = HF0; hs = HS0; hb = HB0; va = VA0; vf = VF0; vs = VS0; vb = VB0;
      pol = POL0; cmd = CMD0;
      for (int i = 0; i < 3; i++) base[i] = BASE0 + BSTEP * i;
      g1 = 0; g2 = 0;
      exp_de = 0; exp_hs = POL0[0]; exp_vs = POL0[1]; exp_pix = 0; exp_uf = 0;
      exp_cv = 0; exp_ca = 0; exp_cw = 0; exp_blk = 0; pend_pop = 0;
    end else begin
      m_act   = (mh < ha) && (mv < va);
      exp_de  = m_act;
      exp_hs  = ((mh >= ha + hf) && (mh < ha + hf + hs)) ^ pol[0];
      exp_vs  = ((mv >= va + vf) && (mv < va + vf + vs)) ^ pol[1];
      exp_blk = m_act && rd_empty;
      exp_pix = (m_act && !rd_empty) ? pix_of(pcnt) : 8'h00;
      pend_pop = m_act && !rd_empty;
      if (exp_blk) exp_uf = 1;
      exp_cv = (mh == 0) && (mv == va + vf);
      if (exp_cv) begin
        m_b = {30'b0, g2[1], g2[1] ^ g2[0]};
        exp_ca = base[(m_b + 2) % 3];
        exp_cw = cmd;
      end
      if (mh >= ha + hf + hs + hb - 1) begin
        mh = 0;
        if (mv >= va + vf + vs + vb - 1) mv = 0; else mv++;
      end else mh++;
      g2 = g1; g1 = wr_idx_gray;
      if (cfg_we) begin
        case (cfg_addr)
          4'd0: ha = cfg_wdata[11:0];  4'd1: hf = cfg_wdata[11:0];
          4'd2: hs = cfg_wdata[11:0];  4'd3: hb = cfg_wdata[11:0];
          4'd4: va = cfg_wdata[11:0];  4'd5: vf = cfg_wdata[11:0];
          4'd6: vs = cfg_wdata[11:0];  4'd7: vb = cfg_wdata[11:0];
          4'd8: pol = cfg_wdata[1:0];
          4'd9: base[0] = cfg_wdata;   4'd10: base[1] = cfg_wdata;
          4'd11: base[2] = cfg_wdata;  4'd12: cmd = cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (run_chk) begin
      chk("R1", "de", de, exp_de);
      chk("R2", "hsync", hsync, exp_hs);
      chk("R3", "vsync", vsync, exp_vs);
      chk(exp_blk ? "R8" : "R7", "pix_out", pix_out, exp_pix);
      chk("R7", "rd_pop", rd_pop, (mh < ha) && (mv < va) && !rd_empty);
      chk("R8", "underflow", underflow, exp_uf);
      chk("R6", "cmd_valid", cmd_valid, exp_cv);
      chk("R5", "cmd_addr", cmd_addr, exp_ca);
      chk("R6", "cmd_word", cmd_word, exp_cw);
    end
    cyc++;
    if (pend_pop) pcnt++;
    pend_pop = 0;
    rd_data = pix_of(pcnt);
    case (empty_mode)
      0: rd_empty = 0;
      1: rd_empty = (cyc % 7 == 3);
      default: rd_empty = 1;
    endcase
  end

  task automatic wr_now(input int a, input logic [31:0] d);
    cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk("R10", "de", de, 0);
    chk("R10", "hsync", hsync, POL0[0]);
    chk("R10", "vsync", vsync, POL0[1]);
    chk("R10", "cmd_valid", cmd_valid, 0);
    chk("R10", "underflow", underflow, 0);
    chk("R10", "pix_out", pix_out, 0);
    rst_n = 1;
    @(negedge clk);
    run_chk = 1;
    repeat (3 * 88) @(negedge clk);

    // Gray index sweep: 00, 01, 11, 10
    for (int g = 0; g < 4; g++) begin
      wr_idx_gray = 2'(g ^ (g >> 1));
      repeat (100) @(negedge clk);
    end

    // polarity writes
    wr_now(8, 32'h2);
    @(negedge clk);
    chk("R4", "hsync after pol write", hsync, exp_hs);
    repeat (90) @(negedge clk);
    wr_now(8, 32'h0);
    repeat (90) @(negedge clk);

    // base write on the request edge (Gray 01 -> buffer 0)
    wr_idx_gray = 2'b01;
    repeat (90) @(negedge clk);
    do @(negedge clk); while (!(mh == 0 && mv == va + vf));
    wr_now(9, 32'h00BE_EF00);
    chk("R4", "cmd_valid at collision", cmd_valid, 1);
    chk("R4", "cmd_addr old base", cmd_addr, BASE0);
    do @(negedge clk); while (!cmd_valid);
    chk("R4", "cmd_addr new base", cmd_addr, 32'h00BE_EF00);
    @(negedge clk);
    wr_now(12, 32'h1234_5678);
    do @(negedge clk); while (!cmd_valid);
    chk("R6", "cmd_word new", cmd_word, 32'h1234_5678);

    // underflow pattern, then full FIFO again
    empty_mode = 1;
    repeat (2 * 88) @(negedge clk);
    empty_mode = 2;
    repeat (20) @(negedge clk);
    empty_mode = 0;
    repeat (88) @(negedge clk);
    chk("R8", "underflow held", underflow, 1);

    // shrink timing mid-line
    do @(negedge clk); while (mh != 8);
    wr_now(0, 1); wr_now(1, 1); wr_now(2, 1); wr_now(3, 1);
    wr_now(4, 1);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk("R9", "de after shrink", de, exp_de);
    end
    repeat (60) @(negedge clk);
    wr_now(0, HA0); wr_now(1, HF0); wr_now(2, HS0); wr_now(3, HB0); wr_now(4, VA0);
    repeat (2 * 88) @(negedge clk);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    #(10 * 200000);
    if (!done) begin
      nmis++;
      $display("FAIL watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
      $finish;
    end
  end
endmodule